// File: doc/BRIEF.md
# Dual delay-chain tap selector

This block samples two single-bit signals into two equal-length shift chains. A
new sample enters each chain on every sample strobe. A signed tap index then
chooses one bit from one chain and pairs it with the newest bit of the other
chain. A downstream index-tracking unit compares the two bits. From transitions
seen in one and not the other, it steers the index toward the delay between the
two inputs.

The sign of the index decides the roles of the chains. A non-negative index
keeps the newest bit of the second chain fixed and sweeps the first chain. A
negative index fixes the newest bit of the first chain and sweeps the second.
One magnitude decoder serves both chains. The second chain's taps are wired to
the decoder outputs in reverse order, so a negative index reads one tap nearer
to the front than its magnitude would suggest. Both picked bits are registered
on the strobe.

Top module: `tapsel_pair`

## Requirements
- R1: A synchronous active-high reset clears every tap of both chains and both outputs to 0.
- R2: On a cycle with the strobe high, each chain shifts by one place. The new input sample enters tap 0 and tap k takes the old value of tap k-1. On a cycle with the strobe low, both chains keep their contents.
- R3: When the index's top bit is 0 and its value is m (0 to TAPS-1), the strobe loads `y_swept` from tap m of the first chain and `y_base` from tap 0 of the second chain.
- R4: When the index's top bit is 1 and the index equals -m in two's complement (m from 1 to TAPS), the strobe loads `y_base` from tap 0 of the first chain and `y_swept` from tap m-1 of the second chain. This is a fixed offset of one tap, left uncorrected.
- R5: The outputs are taken from the chain contents held before the shift of the same strobe, and they change only on a strobe cycle.
- R6: Changes of the index or of the sample inputs while the strobe is low have no effect on the outputs.
- R7: The chain length TAPS is a power-of-two parameter. The index is log2(TAPS)+1 bits wide, so both extreme indices, TAPS-1 and -TAPS, reach the last tap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_en | input | 1 | Sample strobe, one cycle per sample |
| x1 | input | 1 | First input signal |
| x2 | input | 1 | Second input signal |
| tap_idx | input | log2(TAPS)+1 | Signed tap index, two's complement |
| y_swept | output | 1 | Registered bit of the swept chain |
| y_base | output | 1 | Registered bit of the base chain |

## Verification
The bench builds the block with TAPS set to 16, which gives a 5-bit index. At that length every tap of both chains can be filled and swept within a few hundred strobes. Both index extremes, +15 and -16, and the whole negative range with its one-tap offset are covered exhaustively. The short chain also lets a single marker bit be walked end to end, with idle gaps between strobes, so that shift order and hold can be seen at the outputs.

// File: rtl/tapsel_pair.sv
module tapsel_pair #(
  parameter int TAPS = 128,
  localparam int AW = $clog2(TAPS),
  localparam int IW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          smp_en,
  input  logic          x1,
  input  logic          x2,
  input  logic [IW-1:0] tap_idx,
  output logic          y_swept,
  output logic          y_base
);

  logic [TAPS-1:0] ch1, ch2, ch2_rev, sel;

  wire          neg = tap_idx[IW-1];
  wire [AW-1:0] adr = tap_idx[AW-1:0];

  always_comb begin
    sel = '0;
    sel[adr] = 1'b1;
  end

  for (genvar k = 0; k < TAPS; k++) begin : g_rev
    assign ch2_rev[k] = ch2[TAPS-1-k];
  end

  wire hit1     = |(sel & ch1);
  wire hit2     = |(sel & ch2_rev);
  wire sw_nxt   = neg ? hit2 : hit1;
  wire base_nxt = neg ? ch1[0] : ch2[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ch1     <= '0;
      ch2     <= '0;
      y_swept <= 1'b0;
      y_base  <= 1'b0;
    end else if (smp_en) begin
      ch1     <= {ch1[TAPS-2:0], x1};
      ch2     <= {ch2[TAPS-2:0], x2};
      y_swept <= sw_nxt;
      y_base  <= base_nxt;
    end
  end

  assert_clear_R1: assert property (@(posedge clk)
    rst |=> (ch1 == '0 && ch2 == '0 && !y_swept && !y_base));

  assert_shift_R2: assert property (@(posedge clk) disable iff (rst)
    smp_en |=> (ch1 == {$past(ch1[TAPS-2:0]), $past(x1)} &&
                ch2 == {$past(ch2[TAPS-2:0]), $past(x2)}));

  assert_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !smp_en |=> ($stable(ch1) && $stable(ch2)));

  assert_pos_base_R3: assert property (@(posedge clk) disable iff (rst)
    (smp_en && !tap_idx[IW-1]) |=> y_base == $past(ch2[0]));

  assert_pos_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (smp_en && tap_idx == '0) |=> y_swept == $past(ch1[0]));

  assert_neg_base_R4: assert property (@(posedge clk) disable iff (rst)
    (smp_en && tap_idx[IW-1]) |=> y_base == $past(ch1[0]));

  assert_neg_last_R7: assert property (@(posedge clk) disable iff (rst)
    (smp_en && tap_idx == {1'b1, {AW{1'b0}}}) |=> y_swept == $past(ch2[TAPS-1]));

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !smp_en |=> ($stable(y_swept) && $stable(y_base)));

endmodule

// File: tb/tapsel_pair_test.sv
module tapsel_pair_test;
  localparam int TAPS = 16;
  localparam int AW = 4;
  localparam int IW = 5;

  logic clk = 1'b0, rst = 1'b1, smp_en = 1'b0, x1 = 1'b0, x2 = 1'b0;
  logic [IW-1:0] tap_idx = '0;
  logic y_swept, y_base;
  logic m1 [TAPS];
  logic m2 [TAPS];
  logic [15:0] lf = 16'hACE1;
  int vec = 0, bad = 0;
  bit done = 0;

  tapsel_pair #(.TAPS(TAPS)) uut (.clk(clk), .rst(rst), .smp_en(smp_en), .x1(x1),
    .x2(x2), .tap_idx(tap_idx), .y_swept(y_swept), .y_base(y_base));

  always #2 clk = ~clk;

  task automatic chk(string req, logic es, logic eb);
    vec++;
    if (y_swept !== es || y_base !== eb) begin
      bad++;
      $display("FAIL %s: swept=%b base=%b expected swept=%b base=%b", req, y_swept, y_base, es, eb);
    end
  endtask

  task automatic rnd(output logic b);
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    b = lf[0];
  endtask

  task automatic strobe(logic d1, logic d2, string req);
    logic es, eb;
    if (!tap_idx[IW-1]) begin
      es = m1[tap_idx[AW-1:0]]; eb = m2[0];
    end else begin
      int mag = (1 << IW) - int'(tap_idx);
      es = m2[mag-1]; eb = m1[0];
    end
    x1 = d1; x2 = d2; smp_en = 1'b1;
    @(posedge clk); @(negedge clk);
    smp_en = 1'b0;
    for (int k = TAPS-1; k > 0; k--) begin m1[k] = m1[k-1]; m2[k] = m2[k-1]; end
    m1[0] = d1; m2[0] = d2;
    chk(req, es, eb);
  endtask

  task automatic strobe_rnd(string req);
    logic a, b;
    rnd(a); rnd(b);
    strobe(a, b, req);
  endtask

  task automatic do_reset;
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < TAPS; k++) begin m1[k] = 1'b0; m2[k] = 1'b0; end
    chk("R1", 1'b0, 1'b0);
  endtask

  task automatic t_walk;
    do_reset();
    tap_idx = '0;
    strobe(1'b1, 1'b0, "R2");
    for (int k = 0; k < TAPS; k++) begin
      tap_idx = IW'(k);
      repeat (3) begin @(negedge clk); x1 = ~x1; x2 = ~x2; end
      strobe(1'b0, 1'b1, "R2");
    end
  endtask

  task automatic t_pos;
    tap_idx = '0;
    repeat (TAPS) strobe_rnd("R3");
    for (int m = 0; m < TAPS; m++) begin
      tap_idx = IW'(m);
      repeat (3) strobe_rnd("R3");
    end
  endtask

  task automatic t_neg;
    for (int m = 1; m <= TAPS; m++) begin
      tap_idx = IW'(-m);
      repeat (3) strobe_rnd("R4");
    end
  endtask

  task automatic t_hold;
    logic hs, hb;
    tap_idx = IW'(5);
    strobe_rnd("R5");
    hs = y_swept; hb = y_base;
    for (int k = 0; k < 6; k++) begin
      tap_idx = IW'(k * 7); x1 = ~x1; x2 = k[0];
      @(negedge clk);
      chk("R6", hs, hb);
    end
    tap_idx = IW'(-3);
    repeat (4) strobe_rnd("R5");
  endtask

  task automatic t_edges;
    repeat (TAPS) strobe_rnd("R7");
    tap_idx = IW'(TAPS - 1);
    repeat (4) strobe_rnd("R7");
    tap_idx = IW'(-TAPS);
    repeat (4) strobe_rnd("R7");
    do_reset();
    tap_idx = IW'(TAPS - 1);
    strobe(1'b1, 1'b1, "R1");
    tap_idx = IW'(-TAPS);
    strobe(1'b1, 1'b1, "R1");
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    t_walk();
    t_pos();
    t_neg();
    t_hold();
    t_edges();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end
endmodule